// File: doc/BRIEF.md
# Packet controller interrupt status unit

This block holds the interrupt state of a small packet controller: an 8-bit status register, an 8-bit enable mask and a single interrupt line. Event sources elsewhere in the controller pulse one-cycle set strobes into the status register. Two status bits are also driven from queue occupancy. One is held high while the transmit queue is empty. The other is held high while the transmit-completion queue has entries.

Software sees the unit through a byte-wide write port and a byte-wide read port. A write to the acknowledge target clears status bits, but only the bits that the fixed acknowledge mask allows. Bits 0x01 (receive), 0x08 (allocation) and 0x20 (PHY event) stay set until reset. When an acknowledge write carries the transmit-done bit and the completion queue has entries, the unit sends one pop strobe to that queue. A write to the mask target replaces the enable mask. Reads are registered and return either the status or the mask.

Status bit map (MSB to LSB):

| Bit | Value | Meaning |
|---|---|---|
| 7 | 0x80 | management |
| 6 | 0x40 | early receive |
| 5 | 0x20 | PHY event |
| 4 | 0x10 | receive overrun |
| 3 | 0x08 | allocation done |
| 2 | 0x04 | transmit empty |
| 1 | 0x02 | transmit done |
| 0 | 0x01 | receive |

Top module: `nic_irq_unit`

## Requirements
- R1: After synchronous reset the status reads 0x04, the mask reads 0x00, `irq` is 0 and `done_pop` is 0.
- R2: A bit set in `evt_set` on a clock edge appears in the status after that edge. It stays set until an acknowledge clears it or reset occurs.
- R3: An acknowledge write (`wr_en`=1, `wr_sel`=0) clears the written bits that fall within 0xD6 and no others. Bits 0x01, 0x08 and 0x20 are never cleared by a write.
- R4: On every edge where `txq_empty` is 1, status bit 0x04 is set, even if the same edge carries an acknowledge of that bit.
- R5: On every edge where `done_nonempty` is 1, status bit 0x02 is set. The exception is an edge that carries an acknowledge with bit 0x02; that edge clears the bit.
- R6: An acknowledge write with bit 0x02 set while `done_nonempty` is 1 makes `done_pop` high for exactly the following cycle. With `done_nonempty` at 0 it makes no pop.
- R7: `irq` is 1 exactly when the status AND the mask is non-zero. A mask write (`wr_sel`=1) takes effect on `irq` at the same edge that loads the mask.
- R8: When an event set and an acknowledge clear of the same bit fall on one edge, the bit ends up set.
- R9: `rd_data` shows, one edge after it is sampled, the status when `rd_sel` is 0 and the mask when `rd_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | write target: 0 acknowledge, 1 mask |
| wr_data | input | 8 | write byte |
| rd_sel | input | 1 | read source: 0 status, 1 mask |
| rd_data | output | 8 | registered read byte |
| evt_set | input | 8 | one-cycle set strobes, one per status bit |
| txq_empty | input | 1 | transmit queue holds no entries |
| done_nonempty | input | 1 | transmit-completion queue holds entries |
| irq | output | 1 | registered interrupt request |
| done_pop | output | 1 | one-cycle pop of the completion queue |

## Verification
A wrong bit in the status register reaches the ports by two routes. It shows up on the next status read, one edge later. It also reaches `irq` as soon as a mask enables that bit. The bench therefore sweeps every acknowledge byte against a fully set status, and every mask byte against a fixed status pattern. Each result is read back one edge after the write, so a bad clear mask or a bad interrupt reduction shows up within two cycles. Pop faults show up on `done_pop` in the cycle right after the acknowledge. The bench also checks that the completion bit comes back, or stays clear, according to the queue level on the following edge.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_RCV     = 0;
  localparam int BIT_TXDONE  = 1;
  localparam int BIT_TXEMPTY = 2;
  localparam int BIT_ALLOC   = 3;
  localparam int BIT_OVRN    = 4;
  localparam int BIT_PHY     = 5;
  localparam int BIT_EARLY   = 6;
  localparam int BIT_MGMT    = 7;
  localparam logic [STAT_W-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [STAT_W-1:0] STATUS_RESET  = 8'h04;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int            W         = 8,
  parameter logic [W-1:0]  CLR_MASK  = 8'hD6,
  parameter logic [W-1:0]  RST_VAL   = 8'h04,
  parameter int            EMPTY_BIT = 2,
  parameter int            DONE_BIT  = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  input  logic [W-1:0] evt_set,
  input  logic         txq_empty,
  input  logic         done_nonempty,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d
);
  localparam logic [W-1:0] KEEP_MASK = ~CLR_MASK;

  logic [W-1:0] clr_vec;
  logic [W-1:0] force_vec;
  logic         done_acked;

  always_comb begin
    done_acked = ack_we & ack_data[DONE_BIT];
    clr_vec    = ack_we ? (ack_data & CLR_MASK) : '0;
    force_vec  = '0;
    force_vec[EMPTY_BIT] = txq_empty;
    force_vec[DONE_BIT]  = done_nonempty & ~done_acked;
    status_d   = (status_q & ~clr_vec) | evt_set | force_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= RST_VAL;
    else     status_q <= status_d;
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

  assert_sticky_bits_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(status_q) & KEEP_MASK) == ($past(status_q) & KEEP_MASK)));

  assert_empty_forced_R4: assert property (@(posedge clk) disable iff (rst)
    txq_empty |=> status_q[EMPTY_BIT]);

  assert_done_forced_R5: assert property (@(posedge clk) disable iff (rst)
    (done_nonempty && !(ack_we && ack_data[DONE_BIT])) |=> status_q[DONE_BIT]);
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_d
);
  always_comb mask_d = mask_we ? mask_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == $past(mask_data)));
endmodule

// File: rtl/nic_irq_out.sv
module nic_irq_out #(
  parameter int W        = 8,
  parameter int DONE_BIT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_q,
  input  logic [W-1:0] status_d,
  input  logic [W-1:0] mask_q,
  input  logic [W-1:0] mask_d,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  input  logic         done_nonempty,
  input  logic         rd_sel,
  output logic [W-1:0] rd_q,
  output logic         irq_q,
  output logic         pop_q
);
  import nic_irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      pop_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      irq_q <= |(status_d & mask_d);
      pop_q <= ack_we & ack_data[DONE_BIT] & done_nonempty;
      rd_q  <= (reg_sel_e'(rd_sel) == SEL_MASK) ? mask_q : status_q;
    end
  end

  assert_pop_needs_entry_R6: assert property (@(posedge clk) disable iff (rst)
    pop_q |-> $past(done_nonempty));

  assert_read_mask_R9: assert property (@(posedge clk) disable iff (rst)
    rd_sel |=> (rd_q == $past(mask_q)));
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit #(
  parameter int           W          = nic_irq_pkg::STAT_W,
  parameter logic [W-1:0] CLR_MASK   = nic_irq_pkg::ACK_CLEARABLE,
  parameter logic [W-1:0] RST_STATUS = nic_irq_pkg::STATUS_RESET,
  parameter int           EMPTY_BIT  = nic_irq_pkg::BIT_TXEMPTY,
  parameter int           DONE_BIT   = nic_irq_pkg::BIT_TXDONE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] evt_set,
  input  logic         txq_empty,
  input  logic         done_nonempty,
  output logic         irq,
  output logic         done_pop
);
  import nic_irq_pkg::*;

  logic         ack_we;
  logic         mask_we;
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    ack_we  = wr_en & (reg_sel_e'(wr_sel) == SEL_STATUS);
    mask_we = wr_en & (reg_sel_e'(wr_sel) == SEL_MASK);
  end

  nic_irq_status #(
    .W(W), .CLR_MASK(CLR_MASK), .RST_VAL(RST_STATUS),
    .EMPTY_BIT(EMPTY_BIT), .DONE_BIT(DONE_BIT)
  ) u_status (
    .clk(clk), .rst(rst), .ack_we(ack_we), .ack_data(wr_data),
    .evt_set(evt_set), .txq_empty(txq_empty), .done_nonempty(done_nonempty),
    .status_q(status_q), .status_d(status_d)
  );

  nic_irq_mask #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_data(wr_data),
    .mask_q(mask_q), .mask_d(mask_d)
  );

  nic_irq_out #(.W(W), .DONE_BIT(DONE_BIT)) u_out (
    .clk(clk), .rst(rst), .status_q(status_q), .status_d(status_d),
    .mask_q(mask_q), .mask_d(mask_d), .ack_we(ack_we), .ack_data(wr_data),
    .done_nonempty(done_nonempty), .rd_sel(rd_sel),
    .rd_q(rd_data), .irq_q(irq), .pop_q(done_pop)
  );

  assert_irq_matches_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status_q & mask_q)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));
endmodule

// File: tb/nic_irq_unit_bench.sv
module nic_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] evt_set = 8'h00;
  logic       txq_empty = 1'b0;
  logic       done_nonempty = 1'b0;
  logic       irq;
  logic       done_pop;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nic_irq_unit u_nic_irq_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_set(evt_set),
    .txq_empty(txq_empty), .done_nonempty(done_nonempty),
    .irq(irq), .done_pop(done_pop)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample 1 ns after rising edge
  task automatic step(input logic we, input logic sel, input logic [7:0] d,
                      input logic [7:0] ev, input logic te, input logic dn);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; evt_set = ev;
    txq_empty = te; done_nonempty = dn; rd_sel = 1'b0;
    @(posedge clk); #1;
  endtask

  // read returns the register value held before this edge
  task automatic rd(input logic sel, input logic te, input logic dn, output logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b0; evt_set = 8'h00; rd_sel = sel;
    txq_empty = te; done_nonempty = dn;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; evt_set = 8'h00; txq_empty = 1'b0; done_nonempty = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    // R1 reset state
    do_reset();
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pop", {7'd0, done_pop}, 8'h00);
    rd(1'b0, 1'b0, 1'b0, v); chk("R1 status", v, 8'h04);
    rd(1'b1, 1'b0, 1'b0, v); chk("R1 mask", v, 8'h00);

    // R3 / R6 sweep over every acknowledge byte against full status
    for (int a = 0; a < 256; a++) begin
      step(1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
      step(1'b1, 1'b0, 8'(a), 8'h00, 1'b0, 1'b0);
      chk("R6 no pop when empty", {7'd0, done_pop}, 8'h00);
      rd(1'b0, 1'b0, 1'b0, v);
      chk("R3 ack clear", v, 8'hFF & ~(8'(a) & 8'hD6));
    end

    // R2 each event bit sets and stays set
    for (int b = 0; b < 8; b++) begin
      do_reset();
      step(1'b0, 1'b0, 8'h00, 8'(1 << b), 1'b0, 1'b0);
      rd(1'b0, 1'b0, 1'b0, v);
      chk("R2 set", v, 8'h04 | 8'(1 << b));
      step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
      step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
      rd(1'b0, 1'b0, 1'b0, v);
      chk("R2 sticky", v, 8'h04 | 8'(1 << b));
    end

    // R4 transmit-empty re-forced while queue empty
    do_reset();
    step(1'b1, 1'b0, 8'h04, 8'h00, 1'b1, 1'b0);
    rd(1'b0, 1'b1, 1'b0, v); chk("R4 forced", v, 8'h04);
    step(1'b1, 1'b0, 8'h04, 8'h00, 1'b0, 1'b0);
    rd(1'b0, 1'b0, 1'b0, v); chk("R4 clears when nonempty", v, 8'h00);

    // R5 / R6 completion queue handling
    do_reset();
    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    rd(1'b0, 1'b0, 1'b1, v); chk("R5 done set", v, 8'h06);
    step(1'b1, 1'b0, 8'h02, 8'h00, 1'b0, 1'b1);
    chk("R6 pop pulse", {7'd0, done_pop}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R6 pop one cycle", {7'd0, done_pop}, 8'h00);
    rd(1'b0, 1'b0, 1'b1, v); chk("R5 re-forced", v, 8'h06);
    step(1'b1, 1'b0, 8'h02, 8'h00, 1'b0, 1'b1);
    chk("R6 second pop", {7'd0, done_pop}, 8'h01);
    rd(1'b0, 1'b0, 1'b0, v); chk("R5 cleared by ack", v, 8'h04);
    chk("R6 no pop on read", {7'd0, done_pop}, 8'h00);

    // R7 / R9 sweep over every mask byte, status 0x5E
    do_reset();
    step(1'b0, 1'b0, 8'h00, 8'h5A, 1'b0, 1'b0);
    for (int m = 0; m < 256; m++) begin
      step(1'b1, 1'b1, 8'(m), 8'h00, 1'b0, 1'b0);
      chk("R7 irq", {7'd0, irq}, {7'd0, |(8'h5E & 8'(m))});
      if (m % 17 == 0) begin
        rd(1'b1, 1'b0, 1'b0, v); chk("R9 mask read", v, 8'(m));
      end
    end
    rd(1'b0, 1'b0, 1'b0, v); chk("R9 status read", v, 8'h5E);

    // R8 set wins over clear on the same edge
    do_reset();
    step(1'b1, 1'b0, 8'h10, 8'h10, 1'b0, 1'b0);
    rd(1'b0, 1'b0, 1'b0, v); chk("R8 set wins", v, 8'h14);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule